// File: doc/BRIEF.md
# Drift-Corrected Hardware Time Counter

This block keeps a 64-bit nanosecond time value for stamping packets. While running, the value advances by a fixed nominal amount every clock cycle; 16 ns by default, matching a 62.5 MHz timing clock. A drift engine trims the effective frequency by occasionally adding or removing a few nanoseconds. The size and direction of that nudge, and how often it happens, come from one packed 32-bit configuration word.

Software drives the block through a small word-wide register port. It can pause and resume counting with command codes, and it can load a new 64-bit time while paused. It reads the time as a low word then a high word; the high word is captured when the low word is read, so the pair cannot tear across a carry. The configuration word can only be changed while a drift-hold bit is set. Clearing that bit restarts drift counting from zero with the new setting. The `blk_en` input gates the whole counter: while it is low the time is zero, and raising it starts counting from zero.

There are two small state machines. The run machine has states OFF, RUN and PAUSE, with these transitions:
- ENABLE: OFF to RUN when `blk_en` is high.
- DISABLE: any state to OFF when `blk_en` is low.
- STOP: RUN to PAUSE on command 2.
- START: PAUSE to RUN on command 4.

The drift machine has states COUNT and HOLD. ARM (write 1 to the hold register) moves COUNT to HOLD. RELEASE (write 0) moves HOLD to COUNT.

Top module: `tc_time_counter`

## Requirements
- R1: While `blk_en` is low, the time is zero on the cycle after and stays zero; writes to the load registers have no effect. After `blk_en` rises, the first clock edge leaves the time at zero, and counting starts on the next edge.
- R2: In RUN with no correction due, the time grows by exactly 16 each cycle.
- R3: Writing 2 to address 0 pauses the counter, and writing 4 resumes it. Any other value written there changes nothing.
- R4: Address 1 stages the low load word. Writing address 2 while paused loads {written word, staged low word} into the time. A write to address 2 in RUN is ignored.
- R5: A read returns data on `reg_rdata` the cycle after `reg_rd`. Reading address 3 returns the current low time word and captures the high word. Reading address 4 returns that captured high word, not the live one.
- R6: The drift word at address 6 is packed as follows: bits [27:0] hold the period P; bits [30:28] hold the step S in ns; bit 31 is the direction (1 adds S, 0 subtracts S). Its reset value is 0x0FFFFFFF.
- R7: A write to address 6 is accepted only while the hold bit (address 5, bit 0, reads back as written) is 1. Otherwise the stored word is unchanged.
- R8: After RELEASE, let k count the RUN cycles. A correction is applied on each cycle where floor(2k/(2P'+1)) increases, where P' is P, or 1 when P is 0. This gives an average interval of P'·16+8 ns, and the first correction falls on RUN cycle P'+1.
- R9: While the hold bit is 1, no corrections are applied and the interval count is zero.
- R10: A step of 0 leaves the nominal 16 ns/cycle increment unchanged at any period.
- R11: A correction cycle adds between 16−7 and 16+7 ns; a subtracting step is clamped so the increment is never negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_en | input | 1 | Block enable; low forces the time to zero |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| time_ns | output | 64 | Current time in nanoseconds |

## Verification
The assertions check the following on every cycle:
- the time is zero after `blk_en` is low;
- a paused time does not move unless it is loaded;
- every running increment lies within ±7 of nominal;
- a configuration write without the hold bit leaves the word unchanged;
- the interval count is zero while held and never exceeds 2P'.

Only the bench scenarios can show the following:
- the exact number and placement of corrections;
- the field positions of the drift word;
- the snapshot behaviour across a carry;
- that other command codes and writes at the wrong moment are ignored.

The bench does this by sweeping every step, both directions and several periods, and by sweeping the run length around the first correction.

// File: rtl/tc_pkg.sv
package tc_pkg;
    localparam int TC_WORD_W   = 32;
    localparam int TC_PERIOD_W = 28;
    localparam int TC_STEP_W   = 3;
    localparam int TC_ADDR_W   = 3;
    localparam int TC_NOM_INC  = 16;

    localparam int A_CMD       = 0;
    localparam int A_LOAD_LO   = 1;
    localparam int A_LOAD_HI   = 2;
    localparam int A_TIME_LO   = 3;
    localparam int A_TIME_HI   = 4;
    localparam int A_DRIFT_RST = 5;
    localparam int A_DRIFT_CFG = 6;

    localparam int CMD_PAUSE   = 2;
    localparam int CMD_RESUME  = 4;

    localparam logic [31:0] CFG_RESET = 32'h0FFF_FFFF;

    typedef enum logic [1:0] {
        RS_OFF   = 2'd0,
        RS_RUN   = 2'd1,
        RS_PAUSE = 2'd2
    } run_state_e;

    typedef enum logic {
        DS_COUNT = 1'b0,
        DS_HOLD  = 1'b1
    } drift_state_e;

    typedef struct packed {
        logic                   dir;
        logic [TC_STEP_W-1:0]   step;
        logic [TC_PERIOD_W-1:0] period;
    } drift_cfg_t;
endpackage

// File: rtl/tc_run_fsm.sv
module tc_run_fsm
    import tc_pkg::*;
#(
    parameter int WORD_W = TC_WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_en,
    input  logic              cmd_wr,
    input  logic [WORD_W-1:0] cmd_val,
    output run_state_e        state_q,
    output logic              running,
    output logic              paused
);
    run_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RS_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!blk_en) begin
            state_d = RS_OFF;                         // DISABLE
        end else begin
            unique case (state_q)
                RS_OFF:   state_d = RS_RUN;           // ENABLE
                RS_RUN:   if (cmd_wr && cmd_val == WORD_W'(CMD_PAUSE))
                              state_d = RS_PAUSE;     // STOP
                RS_PAUSE: if (cmd_wr && cmd_val == WORD_W'(CMD_RESUME))
                              state_d = RS_RUN;       // START
                default:  state_d = RS_OFF;
            endcase
        end
    end

    always_comb begin
        running = (state_q == RS_RUN);
        paused  = (state_q == RS_PAUSE);
    end
endmodule

// File: rtl/tc_drift.sv
module tc_drift
    import tc_pkg::*;
#(
    parameter int PERIOD_W = TC_PERIOD_W,
    parameter int STEP_W   = TC_STEP_W,
    parameter int NOM_INC  = TC_NOM_INC,
    localparam int ACC_W   = PERIOD_W + 1,
    localparam int INC_W   = $clog2(NOM_INC + (1 << STEP_W)) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_wr,
    input  logic               ctl_bit,
    input  logic               running,
    input  logic               cfg_dir,
    input  logic [STEP_W-1:0]  cfg_step,
    input  logic [PERIOD_W-1:0] cfg_period,
    output drift_state_e       state_q,
    output logic [ACC_W-1:0]   acc_q,
    output logic [INC_W-1:0]   inc
);
    drift_state_e          state_d;
    logic [PERIOD_W-1:0]   eff_period;
    logic [ACC_W-1:0]      thr;
    logic [ACC_W:0]        sum;
    logic                  fire;
    logic [INC_W-1:0]      down;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DS_COUNT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_COUNT: if (ctl_wr && ctl_bit)  state_d = DS_HOLD;   // ARM
            DS_HOLD:  if (ctl_wr && !ctl_bit) state_d = DS_COUNT;  // RELEASE
            default:  state_d = DS_HOLD;
        endcase
    end

    // half-quantum accumulator: +2 per running cycle, threshold 2P'+1
    always_comb begin
        eff_period = (cfg_period == '0) ? PERIOD_W'(1) : cfg_period;
        thr        = {eff_period, 1'b1};
        sum        = {1'b0, acc_q} + (ACC_W+1)'(2);
        fire       = (state_q == DS_COUNT) && running && (sum >= {1'b0, thr});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     acc_q <= '0;
        else if (state_q == DS_HOLD)    acc_q <= '0;
        else if (running) begin
            if (fire) acc_q <= ACC_W'(sum - {1'b0, thr});
            else      acc_q <= ACC_W'(sum);
        end
    end

    generate
        if (((1 << STEP_W) - 1) > NOM_INC) begin : g_clamp
            assign down = (INC_W'(cfg_step) > INC_W'(NOM_INC)) ? INC_W'(NOM_INC)
                                                                : INC_W'(cfg_step);
        end else begin : g_noclamp
            assign down = INC_W'(cfg_step);
        end
    endgenerate

    always_comb begin
        if (!fire)       inc = INC_W'(NOM_INC);
        else if (cfg_dir) inc = INC_W'(NOM_INC) + INC_W'(cfg_step);
        else             inc = INC_W'(NOM_INC) - down;
    end
endmodule

// File: rtl/tc_regs.sv
module tc_regs
    import tc_pkg::*;
#(
    parameter int WORD_W = TC_WORD_W,
    parameter int ADDR_W = TC_ADDR_W,
    localparam int TIME_W = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    input  logic [TIME_W-1:0] time_ns,
    input  logic              paused,
    input  logic              drift_hold,
    output logic [WORD_W-1:0] cfg_q,
    output logic              load_fire,
    output logic [TIME_W-1:0] load_val,
    output logic [WORD_W-1:0] reg_rdata
);
    logic [WORD_W-1:0] load_lo_q;
    logic [WORD_W-1:0] hi_snap_q;
    logic [WORD_W-1:0] rd_d;

    always_comb begin
        load_fire = reg_wr && paused && (reg_addr == ADDR_W'(A_LOAD_HI));
        load_val  = {reg_wdata, load_lo_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_lo_q <= '0;
            cfg_q     <= WORD_W'(CFG_RESET);
        end else if (reg_wr) begin
            if (reg_addr == ADDR_W'(A_LOAD_LO)) load_lo_q <= reg_wdata;
            if (reg_addr == ADDR_W'(A_DRIFT_CFG) && drift_hold) cfg_q <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_W'(A_LOAD_LO):   rd_d = load_lo_q;
            ADDR_W'(A_TIME_LO):   rd_d = time_ns[WORD_W-1:0];
            ADDR_W'(A_TIME_HI):   rd_d = hi_snap_q;
            ADDR_W'(A_DRIFT_RST): rd_d = WORD_W'(drift_hold);
            ADDR_W'(A_DRIFT_CFG): rd_d = cfg_q;
            default:              rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_snap_q <= '0;
            reg_rdata <= '0;
        end else if (reg_rd) begin
            reg_rdata <= rd_d;
            if (reg_addr == ADDR_W'(A_TIME_LO)) hi_snap_q <= time_ns[TIME_W-1:WORD_W];
        end
    end
endmodule

// File: rtl/tc_time_counter.sv
module tc_time_counter
    import tc_pkg::*;
#(
    parameter int WORD_W   = TC_WORD_W,
    parameter int ADDR_W   = TC_ADDR_W,
    parameter int PERIOD_W = TC_PERIOD_W,
    parameter int STEP_W   = TC_STEP_W,
    parameter int NOM_INC  = TC_NOM_INC,
    localparam int TIME_W  = 2 * WORD_W,
    localparam int ACC_W   = PERIOD_W + 1,
    localparam int INC_W   = $clog2(NOM_INC + (1 << STEP_W)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_en,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [TIME_W-1:0] time_ns
);
    run_state_e        run_state;
    drift_state_e      drift_state;
    logic              running;
    logic              paused;
    logic              drift_hold;
    logic [WORD_W-1:0] cfg_q;
    logic              load_fire;
    logic [TIME_W-1:0] load_val;
    logic [ACC_W-1:0]  acc_q;
    logic [INC_W-1:0]  inc;
    logic [TIME_W-1:0] time_q;

    tc_run_fsm #(.WORD_W(WORD_W)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .blk_en  (blk_en),
        .cmd_wr  (reg_wr && reg_addr == ADDR_W'(A_CMD)),
        .cmd_val (reg_wdata),
        .state_q (run_state),
        .running (running),
        .paused  (paused)
    );

    tc_drift #(.PERIOD_W(PERIOD_W), .STEP_W(STEP_W), .NOM_INC(NOM_INC)) u_drift (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_wr     (reg_wr && reg_addr == ADDR_W'(A_DRIFT_RST)),
        .ctl_bit    (reg_wdata[0]),
        .running    (running),
        .cfg_dir    (cfg_q[WORD_W-1]),
        .cfg_step   (cfg_q[PERIOD_W +: STEP_W]),
        .cfg_period (cfg_q[PERIOD_W-1:0]),
        .state_q    (drift_state),
        .acc_q      (acc_q),
        .inc        (inc)
    );

    assign drift_hold = (drift_state == DS_HOLD);

    tc_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .time_ns    (time_q),
        .paused     (paused),
        .drift_hold (drift_hold),
        .cfg_q      (cfg_q),
        .load_fire  (load_fire),
        .load_val   (load_val),
        .reg_rdata  (reg_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       time_q <= '0;
        else if (!blk_en) time_q <= '0;
        else begin
            unique case (run_state)
                RS_OFF:   time_q <= '0;
                RS_RUN:   time_q <= time_q + TIME_W'(inc);
                RS_PAUSE: if (load_fire) time_q <= load_val;
                default:  time_q <= '0;
            endcase
        end
    end

    assign time_ns = time_q;
endmodule

// File: rtl/tc_time_counter_chk.sv
module tc_time_counter_chk
    import tc_pkg::*;
(
    input logic                   clk,
    input logic                   rst_n,
    input logic                   blk_en,
    input logic                   reg_wr,
    input logic [TC_ADDR_W-1:0]   reg_addr,
    input logic [63:0]            time_ns,
    input run_state_e             run_state,
    input logic                   drift_hold,
    input logic [TC_PERIOD_W:0]   acc_q,
    input logic [31:0]            cfg_q
);
    logic [TC_PERIOD_W-1:0] eff_p;
    logic [63:0]            delta;

    always_comb begin
        eff_p = (cfg_q[TC_PERIOD_W-1:0] == '0) ? TC_PERIOD_W'(1) : cfg_q[TC_PERIOD_W-1:0];
        delta = time_ns - 64'(1);
    end

    // R1: disabled block shows zero time
    a_r1_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_en |=> (time_ns == 64'd0));

    // R3: paused time only moves on a load
    a_r3_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && run_state == RS_PAUSE && !(reg_wr && reg_addr == TC_ADDR_W'(A_LOAD_HI)))
        |=> $stable(time_ns));

    // R11: running increment within nominal +/- 7
    a_r11_inc_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_en && run_state == RS_RUN)
        |=> ((time_ns - $past(time_ns)) >= 64'(TC_NOM_INC - 7)
          && (time_ns - $past(time_ns)) <= 64'(TC_NOM_INC + 7)));

    // R7: configuration write guarded by hold bit
    a_r7_cfg_guard: assert property (@(posedge clk) disable iff (!rst_n)
        (!drift_hold && reg_wr && reg_addr == TC_ADDR_W'(A_DRIFT_CFG)) |=> $stable(cfg_q));

    // R9: hold clears interval count
    a_r9_hold_clears: assert property (@(posedge clk) disable iff (!rst_n)
        drift_hold |=> (acc_q == '0));

    // R8: interval count stays below threshold 2P'+1
    a_r8_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q <= {eff_p, 1'b0});

    logic unused_ok;
    assign unused_ok = ^delta;
endmodule

bind tc_time_counter tc_time_counter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .blk_en     (blk_en),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .time_ns    (time_ns),
    .run_state  (run_state),
    .drift_hold (drift_hold),
    .acc_q      (acc_q),
    .cfg_q      (cfg_q)
);

// File: tb/tc_time_counter_bench.sv
module tc_time_counter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        blk_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [63:0] time_ns;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    tc_time_counter u_tc_time_counter (
        .clk(clk), .rst_n(rst_n), .blk_en(blk_en), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // caller sits at a negedge; returns at the next negedge
    task automatic wr(input int a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_rd = 1'b1; reg_addr = 3'(a);
        @(negedge clk);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic run_drift(input logic [31:0] cfg, input int r, output logic [63:0] t);
        logic [31:0] lo, hi;
        wr(0, 2); wr(1, 0); wr(2, 0);
        wr(5, 1); wr(6, cfg); wr(5, 0);
        wr(0, 4);
        repeat (r - 1) @(negedge clk);
        wr(0, 2);
        rd(3, lo); rd(4, hi);
        t = {hi, lo};
    endtask

    function automatic logic [63:0] expect_t(input logic [31:0] cfg, input int r);
        longint p, corr, s;
        p    = (cfg[27:0] == 0) ? 1 : longint'(cfg[27:0]);
        corr = (2 * r) / (2 * p + 1);
        s    = longint'(cfg[30:28]);
        return 64'(16 * r + (cfg[31] ? s * corr : -s * corr));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [63:0] t, t0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check("R1 reset time", time_ns, 64'd0);
        rd(3, d); check("R5 reset low read", 64'(d), 64'd0);
        rd(6, d); check("R6 cfg reset value", 64'(d), 64'h0FFF_FFFF);
        rd(5, d); check("R7 hold bit reset", 64'(d), 64'd0);
        wr(1, 32'h55); wr(2, 32'h9);
        check("R1 load ignored while off", time_ns, 64'd0);

        // enable: first edge keeps zero, then 16 per cycle
        blk_en = 1'b1;
        repeat (10) @(negedge clk);
        check("R1 start from zero", time_ns, 64'd144);
        t0 = time_ns; @(negedge clk);
        check("R2 nominal increment", time_ns - t0, 64'd16);

        // pause, unknown commands, resume
        wr(0, 2); t0 = time_ns;
        wr(0, 3); wr(0, 7); wr(0, 0);
        repeat (4) @(negedge clk);
        check("R3 pause and other codes", time_ns, t0);
        wr(0, 4); t0 = time_ns;
        repeat (5) @(negedge clk);
        check("R3 resume", time_ns - t0, 64'd80);

        // load and snapshot across a carry
        wr(0, 2); wr(1, 32'hFFFF_FFF0); wr(2, 32'h5);
        check("R4 load while paused", time_ns, 64'h5_FFFF_FFF0);
        rd(3, d); check("R5 low read", 64'(d), 64'hFFFF_FFF0);
        wr(0, 4);
        repeat (5) @(negedge clk);
        rd(4, d); check("R5 high from snapshot", 64'(d), 64'h5);
        check("R5 live high carried", 64'(time_ns[63:32]), 64'h6);
        wr(2, 32'hAB);
        check("R4 load ignored while running", 64'(time_ns[63:32]), 64'h6);
        wr(0, 2);
        rd(3, d); t0[31:0] = d; rd(4, d); t0[63:32] = d;
        check("R5 paired read", t0, time_ns);

        // disable returns to zero
        blk_en = 1'b0; @(negedge clk);
        check("R1 disable zeroes", time_ns, 64'd0);
        blk_en = 1'b1; @(negedge clk);

        // configuration guard
        wr(6, 32'h1234_5678); rd(6, d);
        check("R7 cfg write refused", 64'(d), 64'h0FFF_FFFF);
        wr(5, 1); rd(5, d); check("R7 hold readback", 64'(d), 64'd1);
        wr(6, 32'h9234_5678); rd(6, d);
        check("R7 cfg write accepted", 64'(d), 64'h9234_5678);
        wr(5, 0); rd(5, d); check("R7 hold cleared", 64'(d), 64'd0);

        // held drift engine: no corrections
        wr(0, 2); wr(1, 0); wr(2, 0); wr(5, 1); wr(6, 32'hF000_0001);
        wr(0, 4); repeat (29) @(negedge clk); wr(0, 2);
        check("R9 held engine", time_ns, 64'd480);
        wr(5, 0);

        // default word: no correction
        run_drift(32'h0FFF_FFFF, 40, t);
        check("R10 default no correction", t, 64'd640);

        // sweep step, direction, period
        for (int dir = 0; dir < 2; dir++)
            for (int s = 0; s < 8; s++)
                for (int pi = 0; pi < 4; pi++) begin
                    logic [31:0] cfg;
                    int p;
                    p = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : 6;
                    cfg = {1'(dir), 3'(s), 28'(p)};
                    run_drift(cfg, 40, t);
                    if (s == 0)          check("R10 zero step", t, expect_t(cfg, 40));
                    else if (dir == 0 && s == 7) check("R11 subtract max step", t, expect_t(cfg, 40));
                    else                 check("R6 R8 field sweep", t, expect_t(cfg, 40));
                end

        // run-length sweep around the first correction
        for (int r = 1; r <= 12; r++) begin
            run_drift(32'hD000_0002, r, t);
            check("R8 first correction timing", t, expect_t(32'hD000_0002, r));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule